// File: doc/BRIEF.md
# Eight-bit accumulator ALU with packed status flags

This block takes an accumulator byte, a second operand byte, a carry/borrow input and an operation code. It returns an 8-bit result together with an 8-bit flag image. The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, complement of the accumulator, and a rotate left or right through bit 7 / bit 0. The flag image holds five status bits: sign, zero, auxiliary (nibble) carry, even parity and carry. Some operations leave some flags alone, so the block keeps the last flag image in a register. The next result starts from that image.

Operations enter on a valid/ready channel, and results leave on a second valid/ready channel. There is one registered stage between the two channels. A new operation is taken when the result stage is empty or is being drained in the same cycle: `in_ready = !out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, the result and the flag image hold, and no new operation is taken. The flags update only when an operation is accepted. The registered flag image is always visible on `flags`.

Top module: `flag_alu8`

## Requirements
- R1: Op code 0 (add) returns `acc_a + opnd_b`. Op code 1 (add with carry) also adds `carry_in`. The carry flag (bit 0) is the carry out of bit 7.
- R2: Op code 2 (subtract) returns `acc_a - opnd_b`. Op code 3 (subtract with borrow) also subtracts `carry_in`. The carry flag is set when `opnd_b` plus the borrow-in, taken as unsigned, exceeds `acc_a`.
- R3: The auxiliary carry flag (bit 4) shows nibble behaviour. On an add it is set when the low nibbles plus carry-in overflow into bit 4. On a subtract it is set when the low nibble of `opnd_b` plus the borrow-in exceeds the low nibble of `acc_a`.
- R4: Op codes 0 to 6 set three flags from the result. Zero (bit 6) is set when the result is 0x00. Sign (bit 7) copies result bit 7. Parity (bit 2) is set when the result has an even number of 1 bits.
- R5: Op code 4 (AND) clears carry and sets auxiliary carry. Op codes 5 (OR) and 6 (XOR) clear both carry and auxiliary carry.
- R6: Op code 7 returns the bitwise complement of `acc_a` and leaves every flag unchanged.
- R7: Op code 8 rotates left: the result is `{a[6:0],a[7]}` and carry becomes `a[7]`. Op code 9 rotates right: the result is `{a[0],a[7:1]}` and carry becomes `a[0]`. All other flags stay unchanged.
- R8: In the flag image, bits 5 and 3 always read 0 and bit 1 always reads 1. After reset the flag image is 0x02, the result is 0x00 and `out_valid` is low.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `res`, `flags` and `out_valid` hold. Otherwise `in_ready` is high.
- R10: Op codes 10 to 15 return `acc_a` unchanged and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| op | input | 4 | Operation code |
| acc_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry for add-with-carry, borrow for subtract-with-borrow |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| res | output | 8 | Result byte |
| flags | output | 8 | Packed flag image |

## Verification
The hardest case to reach is the flag state that earlier operations leave behind. Complement, rotate and the reserved codes only make sense when checked against flags set earlier. So the bench runs an arithmetic operation first, to set a known mix of sign, zero, parity and auxiliary carry, and then issues the flag-preserving operation. The bench keeps its own running copy of the expected flag image across every scenario. Back-pressure is reached by lowering `out_ready` with a result already held and a second operation waiting. The bench then confirms that the result and `in_ready` hold before it releases the output.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMA = 4'd7,
    OP_RL  = 4'd8,
    OP_RR  = 4'd9
  } alu_op_e;

  typedef enum logic [1:0] {
    UPD_ALL  = 2'd0,
    UPD_CY   = 2'd1,
    UPD_NONE = 2'd2
  } flag_upd_e;

  localparam int FLAG_W = 8;
  localparam int FL_S   = 7;
  localparam int FL_Z   = 6;
  localparam int FL_AC  = 4;
  localparam int FL_P   = 2;
  localparam int FL_CY  = 0;
  localparam logic [FLAG_W-1:0] FLAG_FIXED_MASK = 8'b0010_1010;
  localparam logic [FLAG_W-1:0] FLAG_FIXED_VAL  = 8'b0000_0010;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac
);
  logic [W-1:0]   b_eff;
  logic           c_eff;
  logic [W:0]     full;
  logic [NIB:0]   low;

  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    sum   = full[W-1:0];
    cy    = sub ? ~full[W] : full[W];
    ac    = sub ? ~low[NIB] : low[NIB];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] r,
  output logic         rot_cy
);
  always_comb begin
    rot_cy = 1'b0;
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_CMA:  r = ~a;
      OP_RL: begin
        r      = {a[W-2:0], a[W-1]};
        rot_cy = a[W-1];
      end
      OP_RR: begin
        r      = {a[0], a[W-1:1]};
        rot_cy = a[0];
      end
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      r,
  input  logic              cy,
  input  logic              ac,
  input  flag_upd_e         upd,
  input  logic [FLAG_W-1:0] prev,
  output logic [FLAG_W-1:0] next
);
  logic [FLAG_W-1:0] fresh;

  always_comb begin
    fresh        = FLAG_FIXED_VAL;
    fresh[FL_S]  = r[W-1];
    fresh[FL_Z]  = (r == '0);
    fresh[FL_AC] = ac;
    fresh[FL_P]  = ~^r;
    fresh[FL_CY] = cy;
    unique case (upd)
      UPD_ALL: next = fresh;
      UPD_CY: begin
        next        = prev;
        next[FL_CY] = cy;
      end
      default: next = prev;
    endcase
  end
endmodule

// File: rtl/flag_alu8.sv
module flag_alu8
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [3:0]   op,
  input  logic [W-1:0] acc_a,
  input  logic [W-1:0] opnd_b,
  input  logic         carry_in,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] res,
  output logic [FLAG_W-1:0] flags
);
  localparam int NIB = W / 2;

  alu_op_e           op_e;
  logic              take;
  logic              is_arith, is_sub, use_cin;
  logic [W-1:0]      as_sum, lg_r, nx_res;
  logic              as_cy, as_ac, lg_cy, sel_cy, sel_ac;
  flag_upd_e         upd;
  logic [FLAG_W-1:0] nx_flags;

  assign op_e     = alu_op_e'(op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    is_arith = (op_e == OP_ADD) || (op_e == OP_ADC) || (op_e == OP_SUB) || (op_e == OP_SBB);
    is_sub   = (op_e == OP_SUB) || (op_e == OP_SBB);
    use_cin  = (op_e == OP_ADC) || (op_e == OP_SBB);
  end

  alu8_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .a(acc_a), .b(opnd_b), .cin(use_cin & carry_in), .sub(is_sub),
    .sum(as_sum), .cy(as_cy), .ac(as_ac)
  );

  alu8_logic #(.W(W)) u_logic (
    .a(acc_a), .b(opnd_b), .op(op_e), .r(lg_r), .rot_cy(lg_cy)
  );

  always_comb begin
    nx_res = is_arith ? as_sum : lg_r;
    sel_cy = is_arith ? as_cy : lg_cy;
    sel_ac = is_arith ? as_ac : (op_e == OP_AND);
    if (is_arith || op_e == OP_AND || op_e == OP_OR || op_e == OP_XOR)
      upd = UPD_ALL;
    else if (op_e == OP_RL || op_e == OP_RR)
      upd = UPD_CY;
    else
      upd = UPD_NONE;
  end

  alu8_flags #(.W(W)) u_flags (
    .r(nx_res), .cy(sel_cy), .ac(sel_ac), .upd(upd), .prev(flags), .next(nx_flags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res       <= '0;
      flags     <= FLAG_FIXED_VAL;
    end else if (take) begin
      out_valid <= 1'b1;
      res       <= nx_res;
      flags     <= nx_flags;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_alu8_chk.sv
module flag_alu8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [3:0]   op,
  input logic [W-1:0] acc_a,
  input logic [W-1:0] opnd_b,
  input logic         carry_in,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] res,
  input logic [7:0]   flags
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(flags));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags[5] == 1'b0 && flags[3] == 1'b0 && flags[1] == 1'b1);

  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd0 |=> {flags[0], res} == ({1'b0, $past(acc_a)} + {1'b0, $past(opnd_b)}));

  p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd4 |=> flags[4] && !flags[0]);

  p_cma_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd7 |=> flags == $past(flags) && res == ~$past(acc_a));

  p_rotl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == 4'd8 |=> flags[7:1] == $past(flags[7:1]) && flags[0] == $past(acc_a[W-1]));

  p_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op >= 4'd10 |=> flags == $past(flags) && res == $past(acc_a));
endmodule

bind flag_alu8 flag_alu8_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
  .acc_a(acc_a), .opnd_b(opnd_b), .carry_in(carry_in), .out_valid(out_valid),
  .out_ready(out_ready), .res(res), .flags(flags)
);

// File: tb/test_flag_alu8.sv
`timescale 1ns/1ps
module test_flag_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] op = 4'd0;
  logic [7:0] acc_a = 8'd0;
  logic [7:0] opnd_b = 8'd0;
  logic       carry_in = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] res;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_flags = 8'h02;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu8 i_flag_alu8 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .acc_a(acc_a), .opnd_b(opnd_b), .carry_in(carry_in), .out_valid(out_valid),
    .out_ready(out_ready), .res(res), .flags(flags)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  // reference model: returns {flags, result}
  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic ci,
                                        input logic [7:0] pf);
    logic [8:0] t;
    logic [7:0] r;
    logic       cy, ac, c;
    cy = 1'b0; ac = 1'b0;
    c = (o == 4'd1 || o == 4'd3) ? ci : 1'b0;
    case (o)
      4'd0, 4'd1: begin
        t  = {1'b0, a} + {1'b0, b} + {8'd0, c};
        r  = t[7:0]; cy = t[8];
        ac = ({1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, c}) > 5'd15;
      end
      4'd2, 4'd3: begin
        r  = a - b - {7'd0, c};
        cy = ({1'b0, b} + {8'd0, c}) > {1'b0, a};
        ac = ({1'b0, b[3:0]} + {4'd0, c}) > {1'b0, a[3:0]};
      end
      4'd4: begin r = a & b; ac = 1'b1; end
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: return {pf, ~a};
      4'd8: return {pf[7:1], a[7], a[6:0], a[7]};
      4'd9: return {pf[7:1], a[0], a[0], a[7:1]};
      default: return {pf, a};
    endcase
    return {r[7], (r == 8'd0), 1'b0, ac, 1'b0, ~^r, 1'b1, cy, r};
  endfunction

  task automatic do_op(input string tag, input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] b, input logic ci);
    logic [15:0] e;
    e = model(o, a, b, ci, exp_flags);
    @(negedge clk);
    op = o; acc_a = a; opnd_b = b; carry_in = ci;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {7'd0, out_valid}, 8'd1);
    check({tag, " res"}, res, e[7:0]);
    check({tag, " flags"}, flags, e[15:8]);
    exp_flags = e[15:8];
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R8 reset flags", flags, 8'h02);
    check("R8 reset res", res, 8'h00);
    check("R8 reset valid", {7'd0, out_valid}, 8'd0);
    check("R9 reset ready", {7'd0, in_ready}, 8'd1);
  endtask

  task automatic t_add;
    do_op("R1 add", 4'd0, 8'h12, 8'h34, 1'b1);
    do_op("R1 add carry out", 4'd0, 8'hF0, 8'h20, 1'b0);
    do_op("R1 adc", 4'd1, 8'hFF, 8'h00, 1'b1);
    do_op("R4 sign", 4'd1, 8'h7F, 8'h00, 1'b1);
  endtask

  task automatic t_sub;
    do_op("R2 sub", 4'd2, 8'h50, 8'h20, 1'b1);
    do_op("R2 sub borrow", 4'd2, 8'h10, 8'h20, 1'b0);
    do_op("R2 sbb", 4'd3, 8'h20, 8'h20, 1'b1);
    do_op("R4 zero", 4'd3, 8'h21, 8'h20, 1'b1);
  endtask

  task automatic t_aux;
    do_op("R3 add nibble", 4'd0, 8'h0F, 8'h01, 1'b0);
    do_op("R3 adc nibble", 4'd1, 8'h07, 8'h08, 1'b1);
    do_op("R3 sub nibble", 4'd2, 8'h10, 8'h01, 1'b0);
    do_op("R3 sbb nibble", 4'd3, 8'h35, 8'h05, 1'b1);
  endtask

  task automatic t_logic;
    do_op("R5 and", 4'd4, 8'hF3, 8'h3C, 1'b1);
    do_op("R5 or", 4'd5, 8'h01, 8'h02, 1'b1);
    do_op("R5 xor", 4'd6, 8'hAA, 8'hAA, 1'b1);
    do_op("R4 parity odd", 4'd6, 8'h80, 8'h00, 1'b0);
  endtask

  task automatic t_cma;
    do_op("R6 setup", 4'd2, 8'h10, 8'h21, 1'b0);
    do_op("R6 cma", 4'd7, 8'h5A, 8'hFF, 1'b1);
  endtask

  task automatic t_rot;
    do_op("R7 setup", 4'd0, 8'h88, 8'h88, 1'b0);
    do_op("R7 rotl", 4'd8, 8'h81, 8'h00, 1'b0);
    do_op("R7 rotl nc", 4'd8, 8'h40, 8'h00, 1'b0);
    do_op("R7 rotr", 4'd9, 8'h01, 8'h00, 1'b0);
    do_op("R7 rotr nc", 4'd9, 8'h02, 8'h00, 1'b0);
  endtask

  task automatic t_reserved;
    do_op("R10 setup", 4'd4, 8'h00, 8'hFF, 1'b0);
    do_op("R10 code10", 4'd10, 8'hC3, 8'h11, 1'b1);
    do_op("R10 code15", 4'd15, 8'h3C, 8'h11, 1'b1);
  endtask

  task automatic t_backpressure;
    logic [15:0] e1, e2;
    e1 = model(4'd0, 8'h01, 8'h02, 1'b0, exp_flags);
    e2 = model(4'd2, 8'h09, 8'h03, 1'b0, e1[15:8]);
    @(negedge clk);
    op = 4'd0; acc_a = 8'h01; opnd_b = 8'h02; carry_in = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op = 4'd2; acc_a = 8'h09; opnd_b = 8'h03;
    check("R9 stall ready", {7'd0, in_ready}, 8'd0);
    check("R9 first res", res, e1[7:0]);
    repeat (3) @(negedge clk);
    check("R9 held res", res, e1[7:0]);
    check("R9 held flags", flags, e1[15:8]);
    check("R9 held valid", {7'd0, out_valid}, 8'd1);
    check("R9 still stalled", {7'd0, in_ready}, 8'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 second res", res, e2[7:0]);
    check("R9 second flags", flags, e2[15:8]);
    exp_flags = e2[15:8];
    @(negedge clk);
    check("R9 drained", {7'd0, out_valid}, 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_aux();
    t_logic();
    t_cma();
    t_rot();
    t_reserved();
    t_backpressure();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule